// File: doc/BRIEF.md
# Bidirectional Step-Refining Calibration Search

This block hunts for the setting of an 8-bit trim code that brings some measured quantity, such as an oscillator frequency, into a tolerance window around a target. It does not measure anything itself. Each trial value is presented to an outside compare unit, which returns a three-way verdict: below the window, inside it, or above it.

A search begins at a seed code with a coarse step. Each verdict moves the code toward the target: up for below, down for above. Once the search has seen the code fall on both sides of the target since the last refinement, it halves the step, with a floor of one. The search succeeds as soon as a verdict reports the value inside the window. It also succeeds when, at unit step, the target has been approached from below and from above, and the code last compared is kept as the best fit. A cycle budget, sized by default to two seconds of a 125 MHz clock, aborts a search that does not settle.

A typical use is to run it once for an intermediate-frequency trim, aiming at 110 kHz ±500 Hz, and once for a stereo pilot clock trim, aiming at 38.3 kHz ±31 Hz. The compare unit owns both targets and tolerances.

Top module: `calib_search`

## Requirements
- R1: After reset, `cand_valid`, `done_ok` and `timed_out` are low and `value_out` equals the seed (default 0x80).
- R2: A `start` pulse while no search runs raises `cand_valid` in the next cycle, with `value_out` at the seed, the step at its initial value (default 8), and `done_ok` and `timed_out` cleared. A `start` during a search has no effect on `value_out` or `cand_valid`.
- R3: A verdict `cmp_code` = 2'b00 (inside the window), taken with `cmp_valid` while `cand_valid` is high, ends the search in the next cycle: `done_ok` high, `cand_valid` low, and `value_out` unchanged.
- R4: A verdict of 2'b01 (below) moves `value_out` up by the current step. A verdict of 2'b10 (above) moves it down by the current step, and 2'b11 is handled exactly as 2'b10.
- R5: When both a below and an above verdict have been seen since the last refinement, the step used for the move is half the old step, never less than 1, and both observations are forgotten.
- R6: Moves saturate: `value_out` never wraps past 255 or below 0.
- R7: When, at unit step, a below verdict and an above verdict have both been received, the search ends with `done_ok` high and `value_out` holding the value just compared.
- R8: If a search has not ended after TIMEOUT_CYCLES cycles with `cand_valid` high, it ends with `timed_out` high, `cand_valid` low and `value_out` kept. A finishing verdict in the same cycle as expiry takes priority.
- R9: `cmp_valid` while no search runs is ignored, and `value_out` changes only on a start or an accepted above/below verdict.
- R10: `done_ok` and `timed_out` are never high together or together with `cand_valid`, and each holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (idle only) |
| cmp_valid | input | 1 | A verdict for the presented value is on `cmp_code` |
| cmp_code | input | 2 | 00 inside window, 01 below, 10/11 above |
| cand_valid | output | 1 | A search runs and `value_out` is the value to measure |
| value_out | output | VAL_W | Trial value during a search, final value afterwards |
| done_ok | output | 1 | Search ended with a best fit |
| timed_out | output | 1 | Search aborted by the cycle budget |

## Verification
On every cycle, the assertions check that the three status outputs are mutually exclusive and sticky, that a start loads the seed, and that a verdict moves the code only in its own direction and by no more than the initial step. They also check that an inside verdict ends the search at once, that the code holds steady between verdicts, and that no search outlives its cycle budget. Only the bench's scenarios, compared clock by clock against a reference model, can show the exact halving sequence, the unit-step bracket end point, saturation pinned at 0 and 255, and the precise cycle of the abort.

// File: rtl/calib_search_pkg.sv
package calib_search_pkg;

   // Verdict encoding from the compare unit
   typedef enum logic [1:0] {
      CMP_INSIDE  = 2'b00,
      CMP_BELOW   = 2'b01,
      CMP_ABOVE   = 2'b10,
      CMP_ABOVE_X = 2'b11
   } cmp_code_e;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_SEARCH = 1'b1
   } search_state_e;

endpackage

// File: rtl/calib_search_step.sv
// Step size and direction history for the search.
module calib_search_step #(
   parameter int VAL_W = 8,
   parameter int STEP0 = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             accept,
   input  logic             is_low,
   output logic [VAL_W-1:0] step_q,
   output logic [VAL_W-1:0] step_next,
   output logic             bracket
);

   localparam logic [VAL_W-1:0] STEP_INIT = VAL_W'(STEP0);
   localparam logic [VAL_W-1:0] STEP_UNIT = VAL_W'(1);

   logic seen_low_q, seen_high_q, unit_low_q, unit_high_q;
   logic seen_low_n, seen_high_n, unit_low_n, unit_high_n;
   logic unit_step, both_seen;
   logic [VAL_W-1:0] step_half;

   always_comb begin
      unit_step   = (step_q == STEP_UNIT);
      seen_low_n  = seen_low_q  | is_low;
      seen_high_n = seen_high_q | ~is_low;
      unit_low_n  = unit_low_q  | (is_low  & unit_step);
      unit_high_n = unit_high_q | (~is_low & unit_step);
      both_seen   = seen_low_n & seen_high_n;
      step_half   = step_q >> 1;
      if (both_seen)
         step_next = (step_half == '0) ? STEP_UNIT : step_half;
      else
         step_next = step_q;
      bracket = unit_low_n & unit_high_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q      <= STEP_INIT;
         seen_low_q  <= 1'b0;
         seen_high_q <= 1'b0;
         unit_low_q  <= 1'b0;
         unit_high_q <= 1'b0;
      end else if (load) begin
         step_q      <= STEP_INIT;
         seen_low_q  <= 1'b0;
         seen_high_q <= 1'b0;
         unit_low_q  <= 1'b0;
         unit_high_q <= 1'b0;
      end else if (accept) begin
         step_q      <= step_next;
         seen_low_q  <= seen_low_n  & ~both_seen;
         seen_high_q <= seen_high_n & ~both_seen;
         unit_low_q  <= unit_low_n;
         unit_high_q <= unit_high_n;
      end
   end

endmodule

// File: rtl/calib_search_value.sv
// Trial value register with saturating moves.
module calib_search_value #(
   parameter int VAL_W = 8,
   parameter int SEED  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             move,
   input  logic             go_up,
   input  logic [VAL_W-1:0] step,
   output logic [VAL_W-1:0] value_q
);

   localparam logic [VAL_W-1:0] SEED_V  = VAL_W'(SEED);
   localparam logic [VAL_W-1:0] VAL_TOP = '1;

   logic [VAL_W:0]   sum_ext;
   logic [VAL_W-1:0] up_val, dn_val;

   always_comb begin
      sum_ext = {1'b0, value_q} + {1'b0, step};
      up_val  = sum_ext[VAL_W] ? VAL_TOP : sum_ext[VAL_W-1:0];
      dn_val  = (step > value_q) ? '0 : (value_q - step);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value_q <= SEED_V;
      else if (load)
         value_q <= SEED_V;
      else if (move)
         value_q <= go_up ? up_val : dn_val;
   end

endmodule

// File: rtl/calib_search_timer.sv
// Cycle budget for one search; a parameter removes it entirely.
module calib_search_timer #(
   parameter bit TIMEOUT_EN     = 1'b1,
   parameter int TIMEOUT_CYCLES = 250_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expire
);

   generate
      if (TIMEOUT_EN) begin : g_timer
         localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clear)
               cnt_q <= '0;
            else if (run && cnt_q != LAST)
               cnt_q <= cnt_q + 1'b1;
         end

         assign expire = run && (cnt_q == LAST);
      end else begin : g_no_timer
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clear ^ run;
         assign expire    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/calib_search.sv
// Top: search control, verdict decode and completion flags.
module calib_search
   import calib_search_pkg::*;
#(
   parameter int VAL_W          = 8,
   parameter int SEED           = 128,
   parameter int STEP0          = 8,
   parameter bit TIMEOUT_EN     = 1'b1,
   parameter int TIMEOUT_CYCLES = 250_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_valid,
   input  logic [1:0]       cmp_code,
   output logic             cand_valid,
   output logic [VAL_W-1:0] value_out,
   output logic             done_ok,
   output logic             timed_out
);

   localparam int VAL_SPAN = 1 << VAL_W;

   generate
      if (VAL_W < 2 || VAL_W > 16) begin : g_bad_width
         $error("calib_search: VAL_W out of range");
      end
      if (STEP0 < 1 || STEP0 >= VAL_SPAN) begin : g_bad_step
         $error("calib_search: STEP0 out of range");
      end
      if (SEED < 0 || SEED >= VAL_SPAN) begin : g_bad_seed
         $error("calib_search: SEED out of range");
      end
      if (TIMEOUT_EN && TIMEOUT_CYCLES < 2) begin : g_bad_budget
         $error("calib_search: TIMEOUT_CYCLES too small");
      end
   endgenerate

   search_state_e    state_q;
   logic             ok_q, to_q;
   logic             searching, load, accept, hit, is_low;
   logic             step_accept, finish_ok, move, expire, abort;
   logic             bracket;
   logic [VAL_W-1:0] step_q, step_next;
   cmp_code_e        verdict;

   always_comb begin
      verdict     = cmp_code_e'(cmp_code);
      searching   = (state_q == ST_SEARCH);
      load        = !searching && start;
      accept      = searching && cmp_valid;
      hit         = accept && (verdict == CMP_INSIDE);
      is_low      = (verdict == CMP_BELOW);
      step_accept = accept && !hit;
      finish_ok   = hit || (step_accept && bracket);
      move        = step_accept && !bracket;
      abort       = expire && !finish_ok;
   end

   calib_search_step #(
      .VAL_W (VAL_W),
      .STEP0 (STEP0)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .accept    (step_accept),
      .is_low    (is_low),
      .step_q    (step_q),
      .step_next (step_next),
      .bracket   (bracket)
   );

   calib_search_value #(
      .VAL_W (VAL_W),
      .SEED  (SEED)
   ) u_value (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .move    (move),
      .go_up   (is_low),
      .step    (step_next),
      .value_q (value_out)
   );

   calib_search_timer #(
      .TIMEOUT_EN     (TIMEOUT_EN),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (load),
      .run    (searching),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ok_q    <= 1'b0;
         to_q    <= 1'b0;
      end else if (load) begin
         state_q <= ST_SEARCH;
         ok_q    <= 1'b0;
         to_q    <= 1'b0;
      end else if (searching && finish_ok) begin
         state_q <= ST_IDLE;
         ok_q    <= 1'b1;
      end else if (searching && abort) begin
         state_q <= ST_IDLE;
         to_q    <= 1'b1;
      end
   end

   // step_q is kept for observation by derived blocks; tie into a no-op use
   logic unused_step;
   assign unused_step = ^step_q;

   assign cand_valid = searching;
   assign done_ok    = ok_q;
   assign timed_out  = to_q;

endmodule

// File: rtl/calib_search_chk.sv
// Property checker, attached to every calib_search instance.
module calib_search_chk #(
   parameter int VAL_W          = 8,
   parameter int SEED           = 128,
   parameter int STEP0          = 8,
   parameter bit TIMEOUT_EN     = 1'b1,
   parameter int TIMEOUT_CYCLES = 250_000_000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             cmp_valid,
   input logic [1:0]       cmp_code,
   input logic             cand_valid,
   input logic [VAL_W-1:0] value_out,
   input logic             done_ok,
   input logic             timed_out
);

   localparam logic [VAL_W-1:0] SEED_V = VAL_W'(SEED);

   assert_status_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cand_valid, done_ok, timed_out}));

   assert_ok_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok && !start |=> done_ok);

   assert_to_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out && !start |=> timed_out);

   assert_start_loads_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start && !cand_valid |=> cand_valid && value_out == SEED_V && !done_ok && !timed_out);

   assert_inside_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && cmp_valid && cmp_code == 2'b00 |=> done_ok && !cand_valid && $stable(value_out));

   assert_below_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && cmp_valid && cmp_code == 2'b01 |=> value_out >= $past(value_out));

   assert_above_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && cmp_valid && cmp_code[1] |=> value_out <= $past(value_out));

   // R5 / R6: one move never spans more than the initial step
   assert_move_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && cmp_valid |=>
         ((value_out >= $past(value_out)) ? (value_out - $past(value_out))
                                          : ($past(value_out) - value_out)) <= VAL_W'(STEP0));

   assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && !cmp_valid |=> $stable(value_out));

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cand_valid && !start |=> $stable(value_out) && !cand_valid);

   generate
      if (TIMEOUT_EN) begin : g_budget
         localparam int BW = $clog2(TIMEOUT_CYCLES + 1) + 1;
         logic [BW-1:0] busy_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               busy_cnt <= '0;
            else if (!cand_valid)
               busy_cnt <= '0;
            else if (busy_cnt != '1)
               busy_cnt <= busy_cnt + 1'b1;
         end
         assert_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cand_valid |-> busy_cnt < BW'(TIMEOUT_CYCLES));
      end
   endgenerate

endmodule

bind calib_search calib_search_chk #(
   .VAL_W          (VAL_W),
   .SEED           (SEED),
   .STEP0          (STEP0),
   .TIMEOUT_EN     (TIMEOUT_EN),
   .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .cmp_valid  (cmp_valid),
   .cmp_code   (cmp_code),
   .cand_valid (cand_valid),
   .value_out  (value_out),
   .done_ok    (done_ok),
   .timed_out  (timed_out)
);

// File: tb/calib_search_bench.sv
`timescale 1ns/1ps
module calib_search_bench;

   localparam int SEED  = 128;
   localparam int STEP0 = 8;
   localparam int LIMIT = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       cmp_valid = 1'b0;
   logic [1:0] cmp_code = 2'b00;
   logic       cand_valid, done_ok, timed_out;
   logic [7:0] value_out;

   always #4 clk = ~clk;

   calib_search #(
      .VAL_W (8), .SEED (SEED), .STEP0 (STEP0),
      .TIMEOUT_EN (1'b1), .TIMEOUT_CYCLES (LIMIT)
   ) u_calib_search (
      .clk (clk), .rst_n (rst_n), .start (start),
      .cmp_valid (cmp_valid), .cmp_code (cmp_code),
      .cand_valid (cand_valid), .value_out (value_out),
      .done_ok (done_ok), .timed_out (timed_out)
   );

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";
   bit chk_en = 0;
   bit finished = 0;

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int m_val = SEED, m_step = STEP0, m_timer = 0;
   bit m_busy = 0, m_ok = 0, m_to = 0;
   bit m_lo = 0, m_hi = 0, m_ulo = 0, m_uhi = 0;

   always @(posedge clk) begin
      bit fin;
      bit below;
      if (!rst_n) begin
         m_val = SEED; m_busy = 0; m_ok = 0; m_to = 0; m_step = STEP0;
      end else if (!m_busy) begin
         if (start) begin
            m_busy = 1; m_ok = 0; m_to = 0; m_val = SEED; m_step = STEP0;
            m_lo = 0; m_hi = 0; m_ulo = 0; m_uhi = 0; m_timer = 0;
         end
      end else begin
         fin = 0;
         if (cmp_valid) begin
            if (cmp_code == 2'b00) begin
               fin = 1;
            end else begin
               below = (cmp_code == 2'b01);
               if (below) begin m_lo = 1; if (m_step == 1) m_ulo = 1; end
               else       begin m_hi = 1; if (m_step == 1) m_uhi = 1; end
               if (m_ulo && m_uhi) fin = 1;
               else begin
                  if (m_lo && m_hi) begin
                     m_step = (m_step > 1) ? m_step / 2 : 1;
                     m_lo = 0; m_hi = 0;
                  end
                  if (below) m_val = (m_val + m_step > 255) ? 255 : m_val + m_step;
                  else       m_val = (m_val - m_step < 0) ? 0 : m_val - m_step;
               end
            end
         end
         if (fin) begin m_ok = 1; m_busy = 0; end
         else if (m_timer == LIMIT - 1) begin m_to = 1; m_busy = 0; end
         else m_timer++;
      end
   end

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (chk_en && !finished) begin
         check(cand_valid == m_busy, {cur_req, " model cand_valid"}, cand_valid, m_busy);
         check(value_out == m_val[7:0], {cur_req, " model value_out"}, value_out, m_val);
         check(done_ok == m_ok, {cur_req, " model done_ok"}, done_ok, m_ok);
         check(timed_out == m_to, {cur_req, " model timed_out"}, timed_out, m_to);
      end
   end

   // ---------------- compare-unit responder ----------------
   int  win_lo = 0, win_hi = 0;
   int  resp_delay = 1;
   bit  resp_en = 0;
   bit  alt_high = 0;
   int  force_n = 0;

   function automatic logic [1:0] verdict(input int v);
      if (v < win_lo) return 2'b01;
      if (v > win_hi) return alt_high ? 2'b11 : 2'b10;
      return 2'b00;
   endfunction

   initial begin
      int gap = 0;
      forever begin
         @(negedge clk);
         cmp_valid = 1'b0;
         cmp_code  = 2'b00;
         if (force_n > 0) begin
            cmp_valid = 1'b1;
            force_n--;
         end else if (resp_en && cand_valid) begin
            if (gap >= resp_delay) begin
               cmp_valid = 1'b1;
               cmp_code  = verdict(int'(value_out));
               gap = 0;
            end else gap++;
         end else gap = 0;
      end
   end

   // ---------------- helpers ----------------
   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && cand_valid; i++) @(negedge clk);
   endtask

   task automatic run_search(input int lo, input int hi, input int dly, input bit alt);
      win_lo = lo; win_hi = hi; resp_delay = dly; alt_high = alt; resp_en = 1;
      pulse_start();
      wait_idle();
      @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      int cnt;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(cand_valid == 0, "R1 cand_valid", cand_valid, 0);
      check(value_out == 8'h80, "R1 value_out", value_out, 8'h80);
      check(done_ok == 0 && timed_out == 0, "R1 flags", {done_ok, timed_out}, 0);
      rst_n = 1'b1;
      chk_en = 1;

      // R9: verdicts while idle are ignored
      cur_req = "R9";
      force_n = 3;
      repeat (6) @(negedge clk);
      check(value_out == 8'h80 && !cand_valid && !done_ok, "R9 idle verdicts",
            {cand_valid, done_ok, value_out}, 8'h80);

      // R2 + R3: inside-window finish
      cur_req = "R3";
      win_lo = 8'h7a; win_hi = 8'h7c; resp_delay = 2; alt_high = 0; resp_en = 1;
      pulse_start();
      check(cand_valid && value_out == 8'h80, "R2 seed after start", value_out, 8'h80);
      wait_idle();
      @(negedge clk);
      check(done_ok && value_out == 8'h7c, "R3 inside result", value_out, 8'h7c);

      // R10: flag holds
      cur_req = "R10";
      repeat (5) @(negedge clk);
      check(done_ok && !timed_out && value_out == 8'h7c, "R10 done holds", value_out, 8'h7c);

      // R5 + R7: empty window, bracketing at unit step, back-to-back verdicts
      cur_req = "R7";
      run_search(8'h93, 8'h92, 0, 0);
      check(done_ok && value_out == 8'h92, "R7 bracket best fit", value_out, 8'h92);
      check(!timed_out, "R5 halving converges", timed_out, 0);

      // R4: code 2'b11 behaves like 2'b10
      cur_req = "R4";
      run_search(8'h93, 8'h92, 1, 1);
      check(done_ok && value_out == 8'h92, "R4 alt above code", value_out, 8'h92);

      // R2: start during a search is ignored
      cur_req = "R2";
      win_lo = 8'h40; win_hi = 8'h40; resp_delay = 6; alt_high = 0; resp_en = 1;
      pulse_start();
      for (int i = 0; i < 40 && value_out != 8'h78; i++) @(negedge clk);
      pulse_start();
      check(cand_valid && value_out == 8'h78, "R2 start while busy", value_out, 8'h78);
      wait_idle();
      @(negedge clk);
      check(done_ok && value_out == 8'h40, "R2 search completes", value_out, 8'h40);

      // R6 + R8: always below, saturates at 255 and times out on schedule
      cur_req = "R8";
      win_lo = 1000; win_hi = 2000; resp_delay = 1; resp_en = 1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cnt = 1;
      while (!timed_out && cnt < 2000) begin @(negedge clk); cnt++; end
      check(cnt == LIMIT + 1, "R8 abort cycle", cnt, LIMIT + 1);
      check(timed_out && !done_ok && !cand_valid, "R8 abort flags", {timed_out, done_ok}, 2'b10);
      check(value_out == 8'hff, "R6 upper saturation", value_out, 8'hff);

      // R6: always above, saturates at 0
      cur_req = "R6";
      run_search(-20, -10, 0, 1);
      check(timed_out && value_out == 8'h00, "R6 lower saturation", value_out, 8'h00);

      // R10: a new start clears the abort flag
      cur_req = "R10";
      resp_en = 0;
      pulse_start();
      check(!timed_out && !done_ok && cand_valid, "R10 flags cleared by start",
            {timed_out, done_ok, cand_valid}, 3'b001);
      resp_en = 1; win_lo = 0; win_hi = 255;
      wait_idle();
      @(negedge clk);
      check(done_ok && value_out == 8'h80, "R3 immediate inside at seed", value_out, 8'h80);

      chk_en = 0;
      summary();
      $finish;
   end

endmodule